// File: doc/BRIEF.md
# Adjustable Micro-Frame Start-of-Frame Timer

This block paces the micro-frames of a high-speed serial bus host controller. It counts periods of a reference clock that runs at the high-speed bit rate (480 MHz). On the last clock of every micro-frame it raises a one-cycle start-of-frame strobe, and it advances a running micro-frame index with each strobe. Firmware trims the micro-frame length through a 6-bit length field held in an 8-bit configuration register. Each step of the field adds sixteen bit times to the micro-frame, which lets firmware correct for error in the clock source.

The length field may only change while the controller is halted. The block follows a run/halted status input. It drops any register write that arrives while that input shows running. A small state machine with two states drives the counter. In ST_HALTED the counter is held at zero and no strobe is issued. The transition "start" (run sampled high) moves it to ST_RUNNING and captures the micro-frame length from the field. In ST_RUNNING, the transition "wrap" (last clock of a micro-frame) fires the strobe, clears the counter and captures the length again without leaving the state. The transition "stop" (run sampled low) returns it to ST_HALTED.

Top module: `uframe_sof_timer`

## Requirements
- R1: The configuration register reads as {2'b00, length field}. Bits 7:6 always read zero and ignore writes. Bits 5:0 take the written value when the write is accepted.
- R2: A micro-frame lasts BASE_LEN + 16 × field clocks, with BASE_LEN = 59488 by default. This gives 59488 clocks for field 0 and 60496 clocks for field 63.
- R3: After reset the field holds 32 (register reads 0x20), the strobe is low and the index is zero. A first micro-frame run at that setting lasts 60000 clocks.
- R4: A write that arrives while run_i is 1 is dropped. The register keeps its previous value, and the micro-frame length does not change.
- R5: While run_i is 0 the counter is held at zero and no strobe occurs. Suppose run_i is first sampled high at clock edge e0. The first strobe is then visible after edge e0 + L − 1, where L is the micro-frame length, so the first micro-frame is full length.
- R6: The strobe is high for exactly one clock, on the last clock of each micro-frame.
- R7: The index advances by one in the cycle after each strobe and wraps modulo 2^IDX_W (16384 by default). It holds its value at all other times, including while halted.
- R8: The micro-frame length is captured only at a micro-frame start (the start or wrap transitions). A field rewritten during a halt applies to the fresh micro-frame that follows the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock at the high-speed bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = controller running, 0 = halted |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register read value |
| sof_o | output | 1 | Single-cycle start-of-frame strobe |
| uframe_idx_o | output | IDX_W | Running micro-frame index |

## Verification
A register write sampled at a clock edge shows on cfg_rdata right after that edge. The strobe for a micro-frame of length L appears L − 1 edges after the start edge, and the index moves one edge after the strobe. The bench models these delays cycle by cycle in a behavioural reference and compares all three outputs at every falling edge, where nothing is in transition. The period checks count falling edges from the edge that starts a micro-frame, so a count equal to L means the strobe came on the last clock. One instance uses a short BASE_LEN and a 4-bit index so that every field value and the index wrap fit in the run. A second instance keeps the default parameters and checks the 60000-clock and 60496-clock micro-frames.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;
    typedef enum logic [0:0] {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } sof_state_e;

    localparam int LEN_FIELD_W   = 6;
    localparam int CFG_REG_W     = 8;
    localparam int LEN_FIELD_RST = 32;
endpackage

// File: rtl/sof_len_reg.sv
module sof_len_reg #(
    parameter int FIELD_W = 6,
    parameter int REG_W   = 8,
    parameter int RST_VAL = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halted,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [FIELD_W-1:0] field
);
    localparam int RSVD_W = REG_W - FIELD_W;

    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^wr_data[REG_W-1:FIELD_W];

    // Field changes only on an accepted write, i.e. while halted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field <= FIELD_W'(RST_VAL);
        end else if (wr_en && halted) begin
            field <= wr_data[FIELD_W-1:0];
        end
    end

    assign rd_data = {{RSVD_W{1'b0}}, field};
endmodule

// File: rtl/sof_uframe_fsm.sv
module sof_uframe_fsm
    import sof_timer_pkg::*;
#(
    parameter int BASE_LEN = 59488,
    parameter int LEN_STEP = 16,
    parameter int FIELD_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [FIELD_W-1:0] field,
    output logic               sof
);
    localparam int MAX_LEN = BASE_LEN + LEN_STEP * ((1 << FIELD_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    sof_state_e        state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  len_cur;
    logic [CNT_W-1:0]  frame_len;
    logic              last_clk;

    assign frame_len = CNT_W'(BASE_LEN) + CNT_W'(LEN_STEP) * CNT_W'(field);
    assign last_clk  = (state == ST_RUNNING) && (cnt == len_cur - CNT_W'(1));

    // Next-state decision: start, stop, or stay (wrap stays in RUNNING).
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALTED:  if (run)  state_nxt = ST_RUNNING;
            ST_RUNNING: if (!run) state_nxt = ST_HALTED;
            default:    state_nxt = ST_HALTED;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALTED;
        else        state <= state_nxt;
    end

    // Clock counter and length captured at each micro-frame start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            len_cur <= CNT_W'(BASE_LEN);
        end else begin
            unique case (state)
                ST_HALTED: begin
                    cnt <= '0;
                    if (run) len_cur <= frame_len;
                end
                ST_RUNNING: begin
                    if (!run) begin
                        cnt <= '0;
                    end else if (last_clk) begin
                        cnt     <= '0;
                        len_cur <= frame_len;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Output process.
    always_comb begin
        sof = 1'b0;
        unique case (state)
            ST_HALTED:  sof = 1'b0;
            ST_RUNNING: sof = last_clk;
            default:    sof = 1'b0;
        endcase
    end
endmodule

// File: rtl/sof_index_ctr.sv
module sof_index_ctr #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx <= '0;
        else if (sof) idx <= idx + IDX_W'(1);
    end
endmodule

// File: rtl/uframe_sof_timer.sv
module uframe_sof_timer
    import sof_timer_pkg::*;
#(
    parameter int BASE_LEN = 59488,
    parameter int LEN_STEP = 16,
    parameter int IDX_W    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic             sof_o,
    output logic [IDX_W-1:0] uframe_idx_o
);
    logic [LEN_FIELD_W-1:0] len_field;

    sof_len_reg #(
        .FIELD_W (LEN_FIELD_W),
        .REG_W   (CFG_REG_W),
        .RST_VAL (LEN_FIELD_RST)
    ) u_len_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .halted  (!run_i),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .field   (len_field)
    );

    sof_uframe_fsm #(
        .BASE_LEN (BASE_LEN),
        .LEN_STEP (LEN_STEP),
        .FIELD_W  (LEN_FIELD_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_i),
        .field (len_field),
        .sof   (sof_o)
    );

    sof_index_ctr #(
        .IDX_W (IDX_W)
    ) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .sof   (sof_o),
        .idx   (uframe_idx_o)
    );
endmodule

// File: rtl/sof_timer_chk.sv
module sof_timer_chk #(
    parameter int BASE_LEN = 59488,
    parameter int LEN_STEP = 16,
    parameter int IDX_W    = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             cfg_we,
    input logic [7:0]       cfg_rdata,
    input logic             sof_o,
    input logic [IDX_W-1:0] uframe_idx_o
);
    // Independent window counter: clocks elapsed in the current micro-frame.
    int   win_cnt;
    int   win_len;
    logic win_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt    <= 0;
            win_len    <= 0;
            win_active <= 1'b0;
        end else if (!run_i) begin
            win_cnt    <= 0;
            win_active <= 1'b0;
        end else if (!win_active || sof_o) begin
            win_active <= 1'b1;
            win_cnt    <= 1;
            win_len    <= BASE_LEN + LEN_STEP * int'(cfg_rdata[5:0]);
        end else begin
            win_cnt <= win_cnt + 1;
        end
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:6] == 2'b00);

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (win_active && win_cnt == win_len));

    assert_period_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && win_cnt == win_len) |-> sof_o);

    assert_write_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cfg_we) |=> $stable(cfg_rdata));

    assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sof_o);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |=> !sof_o);

    assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |=> (uframe_idx_o == $past(uframe_idx_o) + IDX_W'(1)));

    assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_o |=> $stable(uframe_idx_o));
endmodule

bind uframe_sof_timer sof_timer_chk #(
    .BASE_LEN (BASE_LEN),
    .LEN_STEP (LEN_STEP),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .cfg_we       (cfg_we),
    .cfg_rdata    (cfg_rdata),
    .sof_o        (sof_o),
    .uframe_idx_o (uframe_idx_o)
);

// File: tb/uframe_sof_timer_test.sv
`timescale 1ns/1ps
module uframe_sof_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int SMALL_BASE = 40;
    localparam int SMALL_IDX  = 4;
    localparam int FULL_BASE  = 59488;
    localparam int STEP       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] rdata_s, rdata_f;
    logic       sof_s, sof_f;
    logic [SMALL_IDX-1:0] idx_s;
    logic [13:0]          idx_f;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uframe_sof_timer #(.BASE_LEN(SMALL_BASE), .LEN_STEP(STEP), .IDX_W(SMALL_IDX)) uut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_s), .sof_o(sof_s), .uframe_idx_o(idx_s));

    uframe_sof_timer uut_full (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_f), .sof_o(sof_f), .uframe_idx_o(idx_f));

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference for the short instance.
    bit m_run;
    int m_cnt, m_len, m_field, m_idx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_len = 0; m_field = 32; m_idx = 0;
        end else begin
            bit fire;
            fire = m_run && (m_cnt == m_len - 1);
            if (fire) m_idx = (m_idx + 1) % (1 << SMALL_IDX);
            if (!m_run) begin
                if (run_i) begin m_run = 1; m_cnt = 0; m_len = SMALL_BASE + STEP * m_field; end
            end else if (!run_i) begin
                m_run = 0; m_cnt = 0;
            end else if (fire) begin
                m_cnt = 0; m_len = SMALL_BASE + STEP * m_field;
            end else begin
                m_cnt++;
            end
            if (cfg_we && !run_i) m_field = int'(cfg_wdata[5:0]);
        end
    end

    always @(negedge clk) begin
        check("R6 strobe vs model", int'(sof_s), int'(m_run && (m_cnt == m_len - 1)));
        check("R7 index vs model", int'(idx_s), m_idx);
        check("R1 register vs model", int'(rdata_s), m_field);
    end

    task automatic set_run(input bit v);
        @(negedge clk); #1; run_i = v;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk); #1; cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); #1; cfg_we = 1'b0;
    endtask

    // Counts falling edges until the chosen strobe is seen; equals L for a full frame.
    task automatic measure(input bit full, output int c);
        c = 0;
        do begin
            @(negedge clk); c++;
        end while (!(full ? sof_f : sof_s));
    endtask

    bit done = 0;

    initial begin
        int c;
        int idx0;
        int vals[6] = '{0, 1, 31, 62, 63, 32};
        repeat (3) @(negedge clk);
        check("R3 reset register small", int'(rdata_s), 8'h20);
        check("R3 reset register full", int'(rdata_f), 8'h20);
        check("R3 reset strobe", int'(sof_f), 0);
        check("R3 reset index", int'(idx_f), 0);
        #1; rst_n = 1'b1;

        // Default-parameter instance: 60000 and 60496 clocks.
        set_run(1);
        measure(1, c);
        check("R3 default micro-frame", c, 60000);
        set_run(0);
        write_cfg(8'd63);
        check("R2 full register 63", int'(rdata_f), 63);
        set_run(1);
        measure(1, c);
        check("R2 full micro-frame field 63", c, FULL_BASE + STEP * 63);
        set_run(0);

        // Short instance: each field value, first frame then steady frame.
        foreach (vals[i]) begin
            set_run(0);
            write_cfg(8'(vals[i]));
            check("R1 field readback", int'(rdata_s), vals[i]);
            set_run(1);
            measure(0, c);
            check("R5 first full micro-frame", c, SMALL_BASE + STEP * vals[i]);
            measure(0, c);
            check("R2 micro-frame period", c, SMALL_BASE + STEP * vals[i]);
            @(negedge clk);
            check("R6 strobe one clock", int'(sof_s), 0);
        end

        // Reserved bits.
        set_run(0);
        write_cfg(8'hFF);
        check("R1 reserved bits read zero", int'(rdata_s), 8'h3F);
        write_cfg(8'h80);
        check("R1 reserved write ignored", int'(rdata_s), 8'h00);

        // Write while running is dropped.
        write_cfg(8'd5);
        set_run(1);
        write_cfg(8'h15);
        check("R4 running write dropped", int'(rdata_s), 5);
        measure(0, c);
        measure(0, c);
        check("R4 length unchanged", c, SMALL_BASE + STEP * 5);

        // Halt mid-frame, rewrite, restart: fresh frame with new length.
        repeat (10) @(negedge clk);
        set_run(0);
        write_cfg(8'd2);
        set_run(1);
        measure(0, c);
        check("R8 new length at fresh frame", c, SMALL_BASE + STEP * 2);

        // Halted: no strobes, index held.
        set_run(0);
        idx0 = int'(idx_s);
        c = 0;
        repeat (300) begin
            @(negedge clk);
            if (sof_s) c++;
        end
        check("R5 no strobe while halted", c, 0);
        check("R7 index held while halted", int'(idx_s), idx0);

        // Index wraps.
        write_cfg(8'd0);
        set_run(1);
        for (int k = 0; k < 20; k++) measure(0, c);
        @(negedge clk);
        check("R7 index wrap", int'(idx_s), (idx0 + 20) % (1 << SMALL_IDX));
        set_run(0);
        repeat (4) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule